// File: doc/BRIEF.md
# Write-Protect Control and Status Register

This block is an 8-bit control and status register that decides whether writes reach a small byte-addressed memory and its adjustable settings. It holds a two-stage write enable made of two volatile latches. The first stage is the general write enable. The second stage is the register enable, and it guards the persistent fields. The register also holds a persistent two-bit lock code and two persistent reset-timing bits, and it shows two external status flags.

Commands arrive as one data byte per cycle on the register-write port. For each array write or setting (wiper) write, the block returns a permit in the same cycle, and that permit is also the acknowledge. A separate power-cycle input models a supply drop and restore. The volatile latches clear on it, and the persistent fields keep their value.

Committing the persistent fields starts an internal write. The block stays busy for a parameterised number of cycles, and no write of any kind is accepted during that time.

Top module: `wprot_csr`

## Requirements
- R1: After `rst_n` is released, every stored bit reads 0. The readback byte is laid out as bit0 = timing bit A, bit1 = write enable, bit2 = register enable, bit3 = lock code bit 0, bit4 = lock code bit 1, bit5 = status flag 2, bit6 = status flag 3, bit7 = timing bit B.
- R2: A one-cycle `pwr_cycle_i` pulse clears the write enable and the register enable on the next edge, ends any busy period, and leaves bits 0, 3, 4 and 7 unchanged.
- R3: While the register enable is 0, writing 0x02 sets the write enable and writing 0x00 clears it. Both are acknowledged at any write-enable value, and neither starts a busy period.
- R4: While the write enable is 0 and the block is not busy, no array or wiper write is permitted, and any register byte other than 0x02 or 0x00 gets no acknowledge and changes nothing.
- R5: Writing 0x06 sets the register enable only when the write enable is already 1, and that write is acknowledged. With the write enable at 0, the same byte is ignored.
- R6: With the write enable at 1 and the register enable at 0, any byte other than 0x00, 0x02 or 0x06 gets no acknowledge and changes nothing.
- R7: With the register enable at 1, a register write is acknowledged and does three things. It loads bits 0, 3, 4 and 7 from the same data bits. It loads the write enable from data bit 1. It raises `busy_o` for exactly BUSY_CYC cycles, and the register enable clears on the edge where busy ends.
- R8: While `busy_o` is 1, no register write is acknowledged, no array or wiper write is permitted, and the stored bits do not change except through R2 and R7.
- R9: An array write is permitted only when the write enable is 1, the block is not busy, and the address is not locked. Lock code 00 locks nothing, 01 locks 0xC0 to 0xFF, 10 locks 0x80 to 0xFF, and 11 locks every address.
- R10: An array write aimed at a locked address while not busy clears the register enable.
- R11: A wiper write is permitted only when the write enable is 1, the block is not busy, and the lock code is 00.
- R12: Readback bits 5 and 6 follow `stat_v2_i` and `stat_v3_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset that clears every stored bit |
| pwr_cycle_i | input | 1 | Supply drop-and-restore pulse |
| reg_wr_i | input | 1 | Register data byte present |
| reg_wdata_i | input | 8 | Register data byte |
| reg_ack_o | output | 1 | Register write acknowledged |
| reg_rdata_o | output | 8 | Current register value |
| stat_v2_i | input | 1 | External status flag shown at bit 5 |
| stat_v3_i | input | 1 | External status flag shown at bit 6 |
| arr_wr_i | input | 1 | Array write request |
| arr_addr_i | input | ADDR_W | Array write address |
| arr_permit_o | output | 1 | Array write permitted and acknowledged |
| wip_wr_i | input | 1 | Wiper write request |
| wip_permit_o | output | 1 | Wiper write permitted and acknowledged |
| busy_o | output | 1 | Persistent commit in progress |

## Verification
Random register bytes are weighted toward the three command codes 0x00, 0x02 and 0x06. Comparing outcomes across these bytes separates the write-enable-only path, the register-enable arming path and the rejection path. A byte sent while the register enable is 1 must instead commit, which shows whether the two latches are chained in the right order. Random addresses over the whole space, tried under every lock code, show whether the quarter and half boundaries sit at 0xC0 and 0x80. Power-cycle pulses injected between and during commits separate the volatile bits from the persistent ones, and writes issued during busy show that the busy window blocks all traffic.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  localparam logic [7:0] CMD_WEL_CLR  = 8'h00;
  localparam logic [7:0] CMD_WEL_SET  = 8'h02;
  localparam logic [7:0] CMD_RWEL_SET = 8'h06;

  typedef struct packed {
    logic tim_b;
    logic lk1;
    logic lk0;
    logic tim_a;
  } nv_t;

  // lock decision from the two top address bits
  function automatic logic lock_hit(input logic [1:0] code, input logic [1:0] top);
    case (code)
      2'b00:   lock_hit = 1'b0;
      2'b01:   lock_hit = &top;
      2'b10:   lock_hit = top[1];
      default: lock_hit = 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] pack_view(input nv_t nv, input logic wel, input logic rwel,
                                           input logic s2, input logic s3);
    pack_view = {nv.tim_b, s3, s2, nv.lk1, nv.lk0, rwel, wel, nv.tim_a};
  endfunction

  function automatic nv_t nv_from_byte(input logic [7:0] d);
    nv_from_byte = '{tim_b: d[7], lk1: d[4], lk0: d[3], tim_a: d[0]};
  endfunction

endpackage

// File: rtl/wprot_decode.sv
module wprot_decode
  import wprot_pkg::*;
(
  input  logic       reg_wr,
  input  logic [7:0] data,
  input  logic       wel,
  input  logic       rwel,
  input  logic       busy,
  output logic       cmd_wel,
  output logic       cmd_rwel_set,
  output logic       cmd_commit,
  output logic       reg_ack
);
  logic go;
  always_comb begin
    go           = reg_wr && !busy;
    cmd_wel      = go && !rwel && (data == CMD_WEL_SET || data == CMD_WEL_CLR);
    cmd_rwel_set = go && !rwel && wel && (data == CMD_RWEL_SET);
    cmd_commit   = go && rwel;
    reg_ack      = cmd_wel || cmd_rwel_set || cmd_commit;
  end
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              arr_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wip_wr,
  input  logic              wel,
  input  logic              busy,
  input  logic [1:0]        code,
  output logic              arr_permit,
  output logic              wip_permit,
  output logic              lock_ev
);
  logic hit;
  always_comb begin
    hit        = lock_hit(code, addr[ADDR_W-1 -: 2]);
    lock_ev    = arr_wr && !busy && hit;
    arr_permit = arr_wr && !busy && wel && !hit;
    wip_permit = wip_wr && !busy && wel && (code == 2'b00);
  end
endmodule

// File: rtl/wprot_nvbank.sv
module wprot_nvbank
  import wprot_pkg::*;
#(
  parameter int BUSY_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_cycle,
  input  logic commit,
  input  nv_t  nv_in,
  output nv_t  nv_q,
  output logic busy,
  output logic commit_done
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q <= '0;
      cnt  <= '0;
    end else begin
      if (commit) nv_q <= nv_in;
      if (pwr_cycle)      cnt <= '0;
      else if (commit)    cnt <= LOAD;
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign busy        = (cnt != '0);
  assign commit_done = (cnt == CW'(1)) && !pwr_cycle;
endmodule

// File: rtl/wprot_csr.sv
module wprot_csr
  import wprot_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BUSY_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_cycle_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic              reg_ack_o,
  output logic [7:0]        reg_rdata_o,
  input  logic              stat_v2_i,
  input  logic              stat_v3_i,
  input  logic              arr_wr_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  output logic              arr_permit_o,
  input  logic              wip_wr_i,
  output logic              wip_permit_o,
  output logic              busy_o
);
  logic wel_q, rwel_q;
  logic cmd_wel, cmd_rwel_set, cmd_commit;
  logic lock_ev, commit_done, busy;
  nv_t  nv_q;

  wprot_decode u_dec (
    .reg_wr(reg_wr_i), .data(reg_wdata_i), .wel(wel_q), .rwel(rwel_q), .busy(busy),
    .cmd_wel(cmd_wel), .cmd_rwel_set(cmd_rwel_set), .cmd_commit(cmd_commit),
    .reg_ack(reg_ack_o)
  );

  wprot_gate #(.ADDR_W(ADDR_W)) u_gate (
    .arr_wr(arr_wr_i), .addr(arr_addr_i), .wip_wr(wip_wr_i), .wel(wel_q), .busy(busy),
    .code({nv_q.lk1, nv_q.lk0}), .arr_permit(arr_permit_o), .wip_permit(wip_permit_o),
    .lock_ev(lock_ev)
  );

  wprot_nvbank #(.BUSY_CYC(BUSY_CYC)) u_nv (
    .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle_i), .commit(cmd_commit),
    .nv_in(nv_from_byte(reg_wdata_i)), .nv_q(nv_q), .busy(busy), .commit_done(commit_done)
  );

  // volatile enable latches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
    end else if (pwr_cycle_i) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
    end else begin
      if (cmd_wel || cmd_commit) wel_q <= reg_wdata_i[1];
      if (lock_ev || commit_done) rwel_q <= 1'b0;
      else if (cmd_rwel_set)      rwel_q <= 1'b1;
    end
  end

  assign busy_o      = busy;
  assign reg_rdata_o = pack_view(nv_q, wel_q, rwel_q, stat_v2_i, stat_v3_i);
endmodule

// File: rtl/wprot_csr_chk.sv
module wprot_csr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_cycle_i,
  input logic       reg_wr_i,
  input logic       reg_ack_o,
  input logic [7:0] reg_rdata_o,
  input logic       arr_wr_i,
  input logic       arr_permit_o,
  input logic       wip_wr_i,
  input logic       wip_permit_o,
  input logic       busy_o,
  input logic       cmd_commit
);
  logic [3:0] nv_view;
  logic       wel_v, rwel_v;
  logic [1:0] code_v;
  assign nv_view = {reg_rdata_o[7], reg_rdata_o[4], reg_rdata_o[3], reg_rdata_o[0]};
  assign wel_v   = reg_rdata_o[1];
  assign rwel_v  = reg_rdata_o[2];
  assign code_v  = reg_rdata_o[4:3];

  p_vol_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle_i |=> (!wel_v && !rwel_v && !busy_o));

  p_nv_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_cycle_i && !cmd_commit) |=> (nv_view == $past(nv_view)));

  p_no_permit_wel0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wel_v |-> (!arr_permit_o && !wip_permit_o));

  p_rwel_needs_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwel_v) |-> $past(wel_v && reg_ack_o));

  p_nv_by_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_view != $past(nv_view)) |-> $past(reg_ack_o && rwel_v));

  p_busy_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!reg_ack_o && !arr_permit_o && !wip_permit_o));

  p_full_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_i && code_v == 2'b11) |-> !arr_permit_o);

  p_lock_clears_rwel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_i && !busy_o && code_v == 2'b11 && !reg_wr_i) |=> !rwel_v);

  p_wip_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_wr_i && code_v != 2'b00) |-> !wip_permit_o);
endmodule

bind wprot_csr wprot_csr_chk i_wprot_csr_chk (
  .clk(clk), .rst_n(rst_n), .pwr_cycle_i(pwr_cycle_i), .reg_wr_i(reg_wr_i),
  .reg_ack_o(reg_ack_o), .reg_rdata_o(reg_rdata_o), .arr_wr_i(arr_wr_i),
  .arr_permit_o(arr_permit_o), .wip_wr_i(wip_wr_i), .wip_permit_o(wip_permit_o),
  .busy_o(busy_o), .cmd_commit(cmd_commit)
);

// File: tb/test_wprot_csr.sv
module test_wprot_csr;
  localparam int AW = 8;
  localparam int BC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr = 1'b0, rwr = 1'b0, s2 = 1'b0, s3 = 1'b0, awr = 1'b0, wwr = 1'b0;
  logic [7:0] wdata = '0, addr = '0, rdata;
  logic ack, aperm, wperm, busy;

  int errors = 0, checks = 0;

  // model state
  logic m_wel = 1'b0, m_rwel = 1'b0, m_ta = 1'b0, m_tb = 1'b0;
  logic [1:0] m_code = 2'b00;
  int m_cnt = 0;

  always #4 clk = ~clk;

  wprot_csr #(.ADDR_W(AW), .BUSY_CYC(BC)) i_wprot_csr (
    .clk(clk), .rst_n(rst_n), .pwr_cycle_i(pwr), .reg_wr_i(rwr), .reg_wdata_i(wdata),
    .reg_ack_o(ack), .reg_rdata_o(rdata), .stat_v2_i(s2), .stat_v3_i(s3),
    .arr_wr_i(awr), .arr_addr_i(addr), .arr_permit_o(aperm), .wip_wr_i(wwr),
    .wip_permit_o(wperm), .busy_o(busy)
  );

  function automatic logic locked(input logic [1:0] c, input logic [7:0] a);
    if (c == 2'b01) return a >= 8'hC0;
    if (c == 2'b10) return a >= 8'h80;
    return c == 2'b11;
  endfunction

  function automatic logic [7:0] exp_view();
    return {m_tb, s3, s2, m_code[1], m_code[0], m_rwel, m_wel, m_ta};
  endfunction

  function automatic logic exp_ack();
    if (!rwr || m_cnt != 0) return 1'b0;
    if (m_rwel) return 1'b1;
    if (wdata == 8'h00 || wdata == 8'h02) return 1'b1;
    return m_wel && wdata == 8'h06;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check before posedge, advance model after it
  task automatic step(input logic p, input logic r, input logic [7:0] d,
                      input logic a, input logic [7:0] ad, input logic w);
    logic ea, ep, ew, bsy;
    @(negedge clk);
    pwr = p; rwr = r; wdata = d; awr = a; addr = ad; wwr = w;
    s2 = 1'($urandom); s3 = 1'($urandom);
    #1;
    bsy = (m_cnt != 0);
    ea  = exp_ack();
    ep  = a && !bsy && m_wel && !locked(m_code, ad);
    ew  = w && !bsy && m_wel && m_code == 2'b00;
    chk(bsy ? "R8 reg ack" : (m_rwel ? "R7 reg ack" :
        ((d == 8'h06) ? "R5 reg ack" : (m_wel ? "R6 reg ack" : "R4 reg ack"))),
        {7'd0, ack}, {7'd0, ea});
    chk(bsy ? "R8 arr permit" : (m_wel ? "R9 arr permit" : "R4 arr permit"),
        {7'd0, aperm}, {7'd0, ep});
    chk(bsy ? "R8 wip permit" : (m_wel ? "R11 wip permit" : "R4 wip permit"),
        {7'd0, wperm}, {7'd0, ew});
    chk("R12 status bits", {6'd0, rdata[6:5]}, {6'd0, s3, s2});
    chk("R3 R7 R10 stored bits", rdata, exp_view());
    chk("R7 busy", {7'd0, busy}, {7'd0, bsy});
    @(posedge clk);
    if (p) begin
      m_wel = 1'b0; m_rwel = 1'b0; m_cnt = 0;
    end else begin
      logic done;
      done = (m_cnt == 1);
      if (m_cnt > 0) m_cnt--;
      if (ea && m_rwel) begin
        m_ta = d[0]; m_code = d[4:3]; m_tb = d[7]; m_wel = d[1]; m_cnt = BC;
      end else if (ea && d == 8'h06) m_rwel = 1'b1;
      else if (ea) m_wel = d[1];
      if (done || (a && !bsy && locked(m_code, ad))) m_rwel = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, 8'h00, 0);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset view", {rdata[7], 2'b00, rdata[4:0]}, 8'h00);
    rst_n = 1'b1;
    idle(2);
    // R5: 0x06 ignored while write enable low
    step(0, 1, 8'h06, 0, 8'h00, 0);
    step(0, 1, 8'h02, 0, 8'h00, 0);            // R3 set
    step(0, 1, 8'h99, 0, 8'h00, 0);            // R6 reject
    step(0, 1, 8'h06, 0, 8'h00, 0);            // R5 arm
    step(0, 1, 8'h8B, 0, 8'h00, 0);            // R7 commit: code 01, tim bits, wel stays
    step(0, 1, 8'h02, 1, 8'h10, 1);            // R8 during busy
    idle(BC);
    step(0, 0, 8'h00, 1, 8'hBF, 0);            // R9 below quarter
    step(0, 0, 8'h00, 1, 8'hC0, 0);            // R9 quarter boundary
    step(0, 0, 8'h00, 0, 8'h00, 1);            // R11 blocked by code
    step(0, 1, 8'h06, 0, 8'h00, 0);
    step(0, 0, 8'h00, 1, 8'hFF, 0);            // R10 lock hit clears enable
    step(1, 0, 8'h00, 0, 8'h00, 0);            // R2 power cycle keeps persistent bits
    idle(2);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int k;
      logic [7:0] d;
      k = int'($urandom_range(99));
      case ($urandom_range(3))
        0: d = 8'h00;
        1: d = 8'h02;
        2: d = 8'h06;
        default: d = 8'($urandom);
      endcase
      if (k < 2)       step(1, 0, 8'h00, 0, 8'h00, 0);
      else if (k < 50) step(0, 1, d, 0, 8'h00, 0);
      else if (k < 75) step(0, 0, 8'h00, 1, 8'($urandom), 0);
      else if (k < 88) step(0, 0, 8'h00, 0, 8'h00, 1);
      else             step(0, 0, 8'h00, 0, 8'h00, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule